// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the access address for a memory that serves bursts of four beats. On a clock edge where the load control is low, the block captures a full external address. That address marks the first beat of a burst. On each later edge where the load control is high, the burst continues and the block moves to the next beat. Only the two least-significant address bits change from beat to beat. The upper bits keep the value captured at load.

A static order input chooses one of two beat orders. In linear order, the low bits are the captured start bits plus the beat number, taken modulo four. In interleaved order, the low bits are the captured start bits XOR the beat number. In both orders the sequence stays inside the aligned group of four addresses and never carries into the upper bits. When the stall input is high, the clock edge is ignored: neither the captured address nor the beat number changes. The current access address is always present on the output. It reflects the state registered at the most recent enabled edge, combined with the order input.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low at a rising clock edge, the state clears. After that edge, acc_addr reads 0.
- R2: On an edge where stall is 0 and load_n is 0, ext_addr is captured. From the next sample, acc_addr equals ext_addr.
- R3: With order_ilv = 0 (linear), the low two bits after the n-th continue edge (stall 0, load_n 1) since the load equal (start + n) mod 4. Here start is bits [1:0] of the captured address.
- R4: With order_ilv = 1 (interleaved), the low two bits after the n-th continue edge equal start XOR (n mod 4).
- R5: On a continue edge, acc_addr bits above bit 1 keep the value captured at load, including when those bits are all ones.
- R6: The fourth continue edge after a load returns acc_addr to the loaded address. The sequence then repeats with period four.
- R7: On an edge where stall is 1, acc_addr does not change, whatever the values of load_n and ext_addr.
- R8: On a continue edge, the value of ext_addr has no effect on acc_addr.
- R9: A load in the middle of a burst restarts the sequence at beat zero from the new address, on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stall | input | 1 | 1 = ignore this clock edge |
| load_n | input | 1 | 0 = capture ext_addr; 1 = continue the burst |
| order_ilv | input | 1 | Static burst order: 0 = linear, 1 = interleaved |
| ext_addr | input | ADDR_W (20) | External starting address |
| acc_addr | output | ADDR_W (20) | Current access address |

## Verification
The assertions check several things on every cycle. A load places the external address on the output. A stalled edge leaves the output unchanged. A continue edge leaves the upper bits alone. In linear order, each continue edge adds exactly one to the low bits, modulo four.

The full interleaved sequence, the return to the start after four continues, and a restart in the middle of a burst depend on the history since the load. Only the bench's sweeps show these. The sweeps cover both orders, all four start offsets and several upper-bit patterns, and compare against arithmetic expectations.

// File: rtl/burst_addr_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: burst length is a power of two.
package burst_addr_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
// Beat counter: counts continue edges since the last load, wrapping at
// the burst length. Assumes stall suppresses every update.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              load_n,
    output logic [BEAT_W-1:0] beat
);
    // Clear on load, step on continue, hold while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (!stall) begin
            if (!load_n) beat <= '0;
            else         beat <= beat + 1'b1;
        end
    end
endmodule

// File: rtl/burst_order_map.sv
// Order mapper: converts the start offset and beat number into the low
// address bits for the chosen order. Purely combinational.
module burst_order_map
    import burst_addr_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] start,
    input  logic [LOW_W-1:0] beat,
    input  burst_order_e     order,
    output logic [LOW_W-1:0] low
);
    logic [LOW_W-1:0] lin_low;
    logic [LOW_W-1:0] ilv_low;

    // Each candidate order wraps inside the aligned group by width alone.
    always_comb begin
        lin_low = start + beat;
        ilv_low = start ^ beat;
        low     = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Top: captures the external address on load and presents the current
// beat address. Assumes order_ilv changes only while no burst is in use,
// and ADDR_W is greater than the low-bit width.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              load_n,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr
);
    localparam int LOW_W = $clog2(BURST_LEN);

    logic [ADDR_W-1:0] base_q;
    logic [LOW_W-1:0]  beat;
    logic [LOW_W-1:0]  low_bits;
    burst_order_e      order;

    // Capture the starting address on an enabled load edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                base_q <= '0;
        else if (!stall && !load_n) base_q <= ext_addr;
    end

    burst_beat_ctr #(.BEAT_W(LOW_W)) u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (stall),
        .load_n (load_n),
        .beat   (beat)
    );

    // Translate the static order pin into the package type.
    always_comb order = burst_order_e'(order_ilv);

    burst_order_map #(.LOW_W(LOW_W)) u_map (
        .start (base_q[LOW_W-1:0]),
        .beat  (beat),
        .order (order),
        .low   (low_bits)
    );

    // Upper bits come straight from the capture register.
    always_comb acc_addr = {base_q[ADDR_W-1:LOW_W], low_bits};

    // R2: a load edge puts the external address on the output.
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stall) && !$past(load_n))
            |-> acc_addr == $past(ext_addr));

    // R7: a stalled edge changes nothing.
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stall) && $stable(order_ilv)) |-> $stable(acc_addr));

    // R5: continue edges never touch the upper bits.
    assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stall) && $past(load_n))
            |-> $stable(acc_addr[ADDR_W-1:LOW_W]));

    // R3: linear order steps the low bits by one modulo the burst length.
    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stall) && $past(load_n) && !order_ilv && !$past(order_ilv))
            |-> acc_addr[LOW_W-1:0] == LOW_W'($past(acc_addr[LOW_W-1:0]) + 1'b1));
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stall = 1'b0;
    logic          load_n = 1'b1;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] acc_addr;

    int n_cmp = 0;
    int n_bad = 0;

    logic [AW-1:0] m_base = '0;
    int            m_n = 0;

    always #2.5 clk = ~clk;

    burst_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .load_n(load_n),
        .order_ilv(order_ilv), .ext_addr(ext_addr), .acc_addr(acc_addr)
    );

    function automatic logic [AW-1:0] model_addr(input logic [AW-1:0] b,
                                                 input int n, input logic ilv);
        logic [1:0] s;
        logic [1:0] k;
        s = b[1:0];
        k = 2'(n % 4);
        return {b[AW-1:2], ilv ? (s ^ k) : 2'(s + k)};
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] exp);
        n_cmp++;
        if (acc_addr !== exp) begin
            n_bad++;
            $display("FAIL %s: acc_addr=%h expected=%h", tag, acc_addr, exp);
        end
    endtask

    task automatic step(input logic s, input logic ld_n, input logic [AW-1:0] a);
        @(negedge clk);
        stall = s; load_n = ld_n; ext_addr = a;
        @(posedge clk);
        #1;
        if (!s) begin
            if (!ld_n) begin m_base = a; m_n = 0; end
            else m_n++;
        end
    endtask

    initial begin
        #(5ns * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [AW-3:0] uppers [3];
        uppers[0] = '0; uppers[1] = '1; uppers[2] = 18'h12345;
        ext_addr = 20'hABCDE;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep both orders, every start offset and several upper patterns.
        for (int ilv = 0; ilv < 2; ilv++) begin
            for (int st = 0; st < 4; st++) begin
                for (int u = 0; u < 3; u++) begin
                    @(negedge clk);
                    order_ilv = ilv[0];
                    step(1'b0, 1'b0, {uppers[u], 2'(st)});
                    check("R2 load", {uppers[u], 2'(st)});
                    for (int c = 1; c <= 6; c++) begin
                        // R8: ext_addr carries junk on continue edges.
                        step(1'b0, 1'b1, ~{uppers[u], 2'(st)});
                        if (c % 4 == 0)
                            check("R6 wrap", {uppers[u], 2'(st)});
                        else if (ilv == 1)
                            check("R4 interleaved / R5 upper", model_addr(m_base, m_n, 1'b1));
                        else
                            check("R3 linear / R5 upper", model_addr(m_base, m_n, 1'b0));
                    end
                end
            end
        end

        // Stall: load attempts and continue attempts both ignored (R7).
        order_ilv = 1'b1;
        step(1'b0, 1'b0, 20'h0F0F1);
        step(1'b0, 1'b1, 20'h00000);
        check("R4 interleaved beat1", 20'h0F0F0);
        step(1'b1, 1'b0, 20'hFFFFF);
        check("R7 stall ignores load", 20'h0F0F0);
        step(1'b1, 1'b1, 20'h12345);
        check("R7 stall ignores continue", 20'h0F0F0);
        step(1'b0, 1'b1, 20'h55555);
        check("R8 continue after stall", 20'h0F0F3);

        // Load in the middle of a burst restarts at beat zero (R9).
        order_ilv = 1'b0;
        step(1'b0, 1'b0, 20'h80002);
        step(1'b0, 1'b1, 20'h0);
        check("R3 linear beat1", 20'h80003);
        step(1'b0, 1'b0, 20'h4000B);
        check("R9 reload", 20'h4000B);
        step(1'b0, 1'b1, 20'h0);
        check("R9 restart beat1", 20'h40008);
        step(1'b0, 1'b1, 20'h0);
        check("R9 restart beat2", 20'h40009);

        // Reset in mid-burst clears the state (R1).
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 reset mid-burst", '0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule